// File: doc/BRIEF.md
# Byte-bus serial port with polled status

This block is a small serial port attached to a byte-wide register bus. Software programs a 16-bit divisor, polls a status byte, writes one character at a time into a data port to send it, and reads received characters from the same port. The serial side is asynchronous 8N1. The line idles high. A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit.

A free-running divisor counter produces a tick at four times the bit rate. Both the transmitter and the receiver count these ticks. The receiver passes its input through a two-stage synchronizer. It then hunts for a low level on a tick and samples every bit on the third tick of that bit. It keeps the last good character in a single holding register. When a new character arrives before the held one was read, an error flag is raised.

Software sets the divisor to clock / (4 × baud) − 1. Bus accesses take one cycle. Read data is combinational from the word index.

Top module: `byte_uart`

## Requirements
- R1: Word index decode. Indexes 0 to 3 read the identification constants ID0 to ID3 (defaults 8'h55, 8'h41, 8'h52, 8'h54). Index 4 is the data port, 5 is status, 6 is the divisor low byte and 7 is the divisor high byte. Status bits other than 7, 5 and 1 read 0.
- R2: After reset, the divisor is 0 and the serial output is high. Status reads 8'hA0, meaning transmit-empty (bit 7) = 1, receive-empty (bit 5) = 1 and overflow (bit 1) = 0.
- R3: With divisor value D, the tick occurs once every D+1 clock cycles. Each transmitted data bit holds the line for exactly 4×(D+1) cycles.
- R4: A write to index 4 while the transmitter is idle drives the start bit from the next cycle. It then sends the eight data bits least significant bit first, then a high stop bit. The line stays high whenever the transmitter is idle.
- R5: Status bit 7 reads 0 from the cycle after an accepted data write. It returns to 1 on the cycle after the fourth tick of the stop bit. A data write while bit 7 is 0 is discarded.
- R6: The receiver starts a frame on a tick that sees the synchronized input low. It samples each bit on the third tick of that bit. It drops the frame if the start bit is high at its sample, or if the stop bit is low. After a low stop bit it waits for the line to return high before it hunts for a new start.
- R7: A good frame stores the byte and clears status bit 5. Reading index 4 returns the stored byte in bits 7:0, and bit 5 reads 1 again from the next cycle.
- R8: When a byte completes while the previous one is unread, status bit 1 is set and the new byte replaces the old. A read of index 4 clears bit 1.
- R9: Writes to indexes 0 to 3 and 5 change nothing.
- R10: Indexes 6 and 7 read back the last value written to them. Together they form the divisor {high, low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ser_rx | input | 1 | Serial receive line, asynchronous |
| ser_tx | output | 1 | Serial transmit line |

## Verification
Register writes take effect at the edge that ends the access, and register reads are valid during the access cycle. A data read changes status from the next cycle. The bench therefore samples read data 1 ns after it drives the access, and it takes the next status reading one cycle later. The transmit line and the transmit-empty bit are due on exact cycles, which a behavioural tick-and-queue model predicts. The bench compares both on every falling edge, with the status index parked on the bus between accesses. Receive results are due mid-stop-bit, 4×(D+1)×9.5 cycles after the start edge plus up to D+3 cycles of synchronizer and tick phase. The bench reads them only after the whole frame has been driven.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;

    localparam int DATA_W      = 8;
    localparam int DIV_W       = 2 * DATA_W;
    localparam int OVERSAMPLE  = 4;
    localparam int SYNC_STAGES = 2;
    localparam int ID_COUNT    = 4;

    localparam int STAT_TXE = 7;
    localparam int STAT_RXE = 5;
    localparam int STAT_OVF = 1;

    typedef enum logic [2:0] {
        IX_ID0  = 3'd0,
        IX_ID1  = 3'd1,
        IX_ID2  = 3'd2,
        IX_ID3  = 3'd3,
        IX_DATA = 3'd4,
        IX_STAT = 3'd5,
        IX_DIVL = 3'd6,
        IX_DIVH = 3'd7
    } reg_ix_e;

    typedef struct packed {
        logic tx_empty;
        logic rx_empty;
        logic overflow;
    } stat_t;

    function automatic logic [DATA_W-1:0] pack_status(stat_t s);
        logic [DATA_W-1:0] b;
        b           = '0;
        b[STAT_TXE] = s.tx_empty;
        b[STAT_RXE] = s.rx_empty;
        b[STAT_OVF] = s.overflow;
        return b;
    endfunction

endpackage

// File: rtl/byte_uart_tick.sv
module byte_uart_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/byte_uart_tx.sv
module byte_uart_tx #(
    parameter int DATA_W = 8,
    parameter int OS     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              line,
    output logic              busy
);
    localparam int SUB_W  = $clog2(OS);
    localparam int LAST   = DATA_W + 1;
    localparam int NBIT_W = $clog2(LAST + 1);

    logic [DATA_W:0]     shreg;
    logic [SUB_W-1:0]    sub;
    logic [NBIT_W-1:0]   nbit;

    always_ff @(posedge clk) begin
        if (rst) begin
            line  <= 1'b1;
            busy  <= 1'b0;
            shreg <= '1;
            sub   <= '0;
            nbit  <= '0;
        end else if (load && !busy) begin
            line  <= 1'b0;
            shreg <= {1'b1, din};
            sub   <= '0;
            nbit  <= '0;
            busy  <= 1'b1;
        end else if (busy && tick) begin
            if (sub == SUB_W'(OS - 1)) begin
                sub <= '0;
                if (nbit == NBIT_W'(LAST)) begin
                    busy <= 1'b0;
                end else begin
                    line  <= shreg[0];
                    shreg <= {1'b1, shreg[DATA_W:1]};
                    nbit  <= nbit + 1'b1;
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/byte_uart_rx.sv
module byte_uart_rx #(
    parameter int DATA_W = 8,
    parameter int OS     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line,
    output logic              done,
    output logic [DATA_W-1:0] dout
);
    localparam int SUB_W  = $clog2(OS);
    localparam int MID    = OS / 2;
    localparam int LAST   = DATA_W + 1;
    localparam int NBIT_W = $clog2(LAST + 1);

    logic                active;
    logic                armed;
    logic [SUB_W-1:0]    sub;
    logic [NBIT_W-1:0]   nbit;
    logic [DATA_W-1:0]   shreg;

    assign dout = shreg;

    always_ff @(posedge clk) begin
        done <= 1'b0;
        if (rst) begin
            active <= 1'b0;
            armed  <= 1'b1;
            sub    <= '0;
            nbit   <= '0;
            shreg  <= '0;
        end else if (tick) begin
            if (!active) begin
                if (!armed) begin
                    if (line) armed <= 1'b1;
                end else if (!line) begin
                    active <= 1'b1;
                    sub    <= SUB_W'(1);
                    nbit   <= '0;
                end
            end else begin
                sub <= sub + 1'b1;
                if (sub == SUB_W'(MID)) begin
                    nbit <= nbit + 1'b1;
                    if (nbit == '0) begin
                        if (line) active <= 1'b0;
                    end else if (nbit == NBIT_W'(LAST)) begin
                        active <= 1'b0;
                        if (line) done  <= 1'b1;
                        else      armed <= 1'b0;
                    end else begin
                        shreg <= {line, shreg[DATA_W-1:1]};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/byte_uart.sv
module byte_uart
    import byte_uart_pkg::*;
#(
    parameter logic [7:0] ID0 = 8'h55,
    parameter logic [7:0] ID1 = 8'h41,
    parameter logic [7:0] ID2 = 8'h52,
    parameter logic [7:0] ID3 = 8'h54
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       ser_rx,
    output logic       ser_tx
);
    localparam logic [DATA_W-1:0] ID_WORDS [ID_COUNT] = '{ID0, ID1, ID2, ID3};

    logic [DATA_W-1:0]      div_lo, div_hi;
    logic [DATA_W-1:0]      hold;
    logic                   rx_full, ovf;
    logic                   tick, tx_busy, rx_done;
    logic [DATA_W-1:0]      rx_byte;
    logic [SYNC_STAGES-1:0] rx_sync;
    logic [DATA_W-1:0]      stat_byte;
    logic                   wr_data, rd_data;
    reg_ix_e                ix;

    assign ix      = reg_ix_e'(bus_addr);
    assign wr_data = bus_sel &&  bus_wr && ix == IX_DATA;
    assign rd_data = bus_sel && !bus_wr && ix == IX_DATA;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_lo <= '0;
            div_hi <= '0;
        end else if (bus_sel && bus_wr) begin
            if (ix == IX_DIVL) div_lo <= bus_wdata;
            if (ix == IX_DIVH) div_hi <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rx_sync <= '1;
        else     rx_sync <= {rx_sync[SYNC_STAGES-2:0], ser_rx};
    end

    byte_uart_tick #(.DIV_W(DIV_W)) u_tick (
        .clk (clk),
        .rst (rst),
        .div ({div_hi, div_lo}),
        .tick(tick)
    );

    byte_uart_tx #(.DATA_W(DATA_W), .OS(OVERSAMPLE)) u_tx (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .load(wr_data),
        .din (bus_wdata),
        .line(ser_tx),
        .busy(tx_busy)
    );

    byte_uart_rx #(.DATA_W(DATA_W), .OS(OVERSAMPLE)) u_rx (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .line(rx_sync[SYNC_STAGES-1]),
        .done(rx_done),
        .dout(rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold    <= '0;
            rx_full <= 1'b0;
            ovf     <= 1'b0;
        end else if (rx_done) begin
            hold    <= rx_byte;
            rx_full <= 1'b1;
            ovf     <= rd_data ? 1'b0 : (ovf | rx_full);
        end else if (rd_data) begin
            rx_full <= 1'b0;
            ovf     <= 1'b0;
        end
    end

    assign stat_byte = pack_status('{tx_empty: !tx_busy, rx_empty: !rx_full, overflow: ovf});

    always_comb begin
        case (ix)
            IX_DATA: bus_rdata = hold;
            IX_STAT: bus_rdata = stat_byte;
            IX_DIVL: bus_rdata = div_lo;
            IX_DIVH: bus_rdata = div_hi;
            default: bus_rdata = ID_WORDS[bus_addr[1:0]];
        endcase
    end
endmodule

// File: rtl/byte_uart_chk.sv
module byte_uart_chk #(
    parameter logic [7:0] ID_WORD0 = 8'h55
) (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       ser_tx,
    input logic [7:0] stat,
    input logic       rx_done,
    input logic [7:0] div_lo,
    input logic [7:0] div_hi
);
    logic rd_d, wr_d, div_wr;
    assign rd_d   = bus_sel && !bus_wr && bus_addr == 3'd4;
    assign wr_d   = bus_sel &&  bus_wr && bus_addr == 3'd4;
    assign div_wr = bus_sel &&  bus_wr && bus_addr[2:1] == 2'b11;

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        stat[7] |-> ser_tx);                                        // R4

    AST_WRITE_TAKES_TX: assert property (@(posedge clk) disable iff (rst)
        (wr_d && stat[7]) |=> !stat[7]);                            // R5

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (rd_d && !rx_done) |=> (stat[5] && !stat[1]));              // R7

    AST_OVF_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        stat[1] |-> !stat[5]);                                      // R8

    AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !div_wr |=> $stable({div_hi, div_lo}));                     // R10

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 3'd0) |-> bus_rdata == ID_WORD0);              // R1
endmodule

bind byte_uart byte_uart_chk #(.ID_WORD0(ID0)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .ser_tx   (ser_tx),
    .stat     (stat_byte),
    .rx_done  (rx_done),
    .div_lo   (div_lo),
    .div_hi   (div_hi)
);

// File: tb/sim_byte_uart.sv
`timescale 1ns/1ps
module sim_byte_uart;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd5;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ser_rx = 1'b1;
    logic       ser_tx;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    byte_uart u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_rx(ser_rx), .ser_tx(ser_tx)
    );

    // behavioural model of tick, divisor and transmit line
    int  m_cnt = 0;
    int  m_div = 0;
    int  m_sub = 0;
    bit  m_line = 1'b1;
    bit  m_busy = 1'b0;
    bit  m_tick;
    int  m_q[$];

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_div = 0; m_sub = 0; m_line = 1'b1; m_busy = 1'b0;
            m_q.delete();
        end else begin
            m_tick = (m_cnt >= m_div);
            m_cnt  = m_tick ? 0 : m_cnt + 1;
            if (bus_sel && bus_wr && bus_addr == 3'd4 && !m_busy) begin
                m_busy = 1'b1; m_line = 1'b0; m_sub = 0;
                m_q.delete();
                for (int i = 0; i < 8; i++) m_q.push_back(int'(bus_wdata[i]));
                m_q.push_back(1);
            end else if (m_busy && m_tick) begin
                m_sub++;
                if (m_sub == 4) begin
                    m_sub = 0;
                    if (m_q.size() == 0) m_busy = 1'b0;
                    else m_line = bit'(m_q.pop_front());
                end
            end
            if (bus_sel && bus_wr && bus_addr == 3'd6) m_div = (m_div & 32'hFF00) | int'(bus_wdata);
            if (bus_sel && bus_wr && bus_addr == 3'd7) m_div = (m_div & 32'h00FF) | (int'(bus_wdata) << 8);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison of line and transmit-empty against the model
    always @(negedge clk) begin
        #3;
        if (!rst) begin
            check(ser_tx == m_line, "R4 line", int'(ser_tx), int'(m_line));
            if (!bus_sel && bus_addr == 3'd5)
                check(bus_rdata[7] == !m_busy, "R5 txe", int'(bus_rdata[7]), int'(!m_busy));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 3'd5;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_addr = 3'd5;
    endtask

    task automatic wait_tx_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input logic stopb, input int bitlen);
        logic [9:0] fr;
        fr = {stopb, d, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ser_rx = fr[i];
            repeat (bitlen - 1) @(negedge clk);
        end
        @(negedge clk);
        ser_rx = 1'b1;
        repeat (bitlen) @(negedge clk);
    endtask

    task automatic high_len(input int exp, input string req);
        int n;
        @(negedge clk);
        while (ser_tx == 1'b0) @(negedge clk);
        n = 0;
        while (ser_tx == 1'b1 && n < 100000) begin n++; @(negedge clk); end
        check(n == exp, req, n, exp);
    endtask

    initial begin
        #1_500_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        check(ser_tx == 1'b1, "R2 line", int'(ser_tx), 1);
        rd(3'd5, v); check(v == 8'hA0, "R2 status", v, 8'hA0);
        rd(3'd6, v); check(v == 8'h00, "R2 divlo", v, 0);
        rd(3'd7, v); check(v == 8'h00, "R2 divhi", v, 0);

        // R1 identification words
        rd(3'd0, v); check(v == 8'h55, "R1 id0", v, 8'h55);
        rd(3'd1, v); check(v == 8'h41, "R1 id1", v, 8'h41);
        rd(3'd2, v); check(v == 8'h52, "R1 id2", v, 8'h52);
        rd(3'd3, v); check(v == 8'h54, "R1 id3", v, 8'h54);

        // R4 transmit with divisor 0, model compared per cycle
        wr(3'd4, 8'hC3);
        wait_tx_idle();

        // R10 divisor readback, R3 bit length with D=1
        wr(3'd6, 8'h01);
        rd(3'd6, v); check(v == 8'h01, "R10 divlo", v, 1);
        wr(3'd4, 8'h55);
        high_len(8, "R3 bit D=1");
        // R5 write while busy is dropped (model ignores it too)
        wr(3'd4, 8'h3C);
        rd(3'd5, v); check(v[7] == 1'b0, "R5 busy", v, 8'h20);
        wait_tx_idle();
        rd(3'd5, v); check(v == 8'hA0, "R5 idle again", v, 8'hA0);

        // R3 wide divisor using both bytes: 0x0102 -> 259 cycles per tick
        wr(3'd7, 8'h01);
        wr(3'd6, 8'h02);
        rd(3'd7, v); check(v == 8'h01, "R10 divhi", v, 1);
        wr(3'd4, 8'h55);
        high_len(4 * 259, "R3 bit D=258");
        wait_tx_idle();

        // R9 writes to ID and status ignored
        wr(3'd0, 8'h00);
        wr(3'd3, 8'hFF);
        wr(3'd5, 8'h00);
        rd(3'd0, v); check(v == 8'h55, "R9 id0", v, 8'h55);
        rd(3'd3, v); check(v == 8'h54, "R9 id3", v, 8'h54);
        rd(3'd5, v); check(v == 8'hA0, "R9 status", v, 8'hA0);

        // receive with D=3 (bit = 16 cycles)
        wr(3'd7, 8'h00);
        wr(3'd6, 8'h03);
        send_rx(8'h3C, 1'b1, 16);
        rd(3'd5, v); check(v == 8'h80, "R7 full", v, 8'h80);
        rd(3'd4, v); check(v == 8'h3C, "R6 data", v, 8'h3C);
        rd(3'd5, v); check(v == 8'hA0, "R7 emptied", v, 8'hA0);

        // R8 overflow
        send_rx(8'h11, 1'b1, 16);
        send_rx(8'hE7, 1'b1, 16);
        rd(3'd5, v); check(v == 8'h82, "R8 ovf set", v, 8'h82);
        rd(3'd4, v); check(v == 8'hE7, "R8 newest", v, 8'hE7);
        rd(3'd5, v); check(v == 8'hA0, "R8 ovf clear", v, 8'hA0);

        // R6 low stop bit: frame dropped, no false frame afterwards
        send_rx(8'h00, 1'b0, 16);
        repeat (80) @(negedge clk);
        rd(3'd5, v); check(v == 8'hA0, "R6 bad stop", v, 8'hA0);

        // R6 one-cycle glitch is not a frame
        @(negedge clk); ser_rx = 1'b0;
        @(negedge clk); ser_rx = 1'b1;
        repeat (200) @(negedge clk);
        rd(3'd5, v); check(v == 8'hA0, "R6 glitch", v, 8'hA0);

        // R6 receiver still works, different divisor D=5 (bit = 24 cycles)
        wr(3'd6, 8'h05);
        send_rx(8'hA6, 1'b1, 24);
        rd(3'd4, v); check(v == 8'hA6, "R6 data D=5", v, 8'hA6);

        // concurrent transmit and receive status
        wr(3'd4, 8'h0F);
        rd(3'd5, v); check(v == 8'h20, "R5 busy + R7 empty", v, 8'h20);
        wait_tx_idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule